// File: doc/BRIEF.md
# Dual-Source Programming Control Register

This block is a small control register that two independent masters can write. The CPU reaches it through a module/index register bus. A JTAG test access port reaches it through a parallel update strobe from its data register. The register holds a two-bit programming-interface select field and a boot-enable bit. Each of these bits has a separate copy for each master. A CPU read returns the OR of the two copies. A CPU write to the register clears the JTAG copy of the select field. The JTAG copy of the boot-enable bit is cleared when a run-on-debug style clear input is raised.

The merged boot-enable bit sets the boot vector for the next reset. A value of 0 selects application code at address 0000h, and a value of 1 selects the in-system programming loader. The block captures this choice while the system reset is held and keeps it until the next system reset. The control bits are cleared only by the power-on reset and by the test-logic reset. Bit 0 of the register word is a transfer-complete flag that lives outside the block. It passes through on reads, and CPU writes to it leave the block on a write strobe.

Top module: `prog_ctl_reg`

## Requirements
- R1: A CPU read that hits the register returns a word with this layout: bit 0 is the `xferDone` input, bit 1 is the merged boot enable, and bits 3:2 are the merged source select. All bits above bit 3 read 0. A read that does not hit returns 0.
- R2: The source-select bits that a read returns are the bitwise OR of the CPU copy and the JTAG copy.
- R3: The boot-enable bit that a read returns is the OR of the CPU copy and the JTAG copy.
- R4: A CPU write that hits the register loads the CPU copies from data bits 3:2 and bit 1 on that clock edge. The same write clears the JTAG source-select copy and leaves the JTAG boot-enable copy unchanged.
- R5: If a CPU write and a JTAG update occur in the same cycle, the JTAG source-select copy ends up 0, while the JTAG boot-enable copy still loads from the update.
- R6: While `jtagRod` is high, the JTAG boot-enable copy is cleared on the next edge. This takes priority over a JTAG update in the same cycle, and that update still loads the JTAG source-select copy.
- R7: Both `porRst_n` low and a `tlr` pulse clear all four copies. `sysRst` leaves all four copies unchanged.
- R8: On every edge where `sysRst` is high, `bootSel` loads the merged boot enable. While `sysRst` is low, `bootSel` holds its value. `porRst_n` clears it to 0.
- R9: `progIfSel` equals the merged source select while the merged boot enable is 1, and equals 0 otherwise.
- R10: During a CPU write that hits the register, `xferWrStrobe` is high in the same cycle and `xferWrData` carries data bit 0. At all other times the strobe is low.
- R11: A write to any other module or index changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Asynchronous power-on reset, active low |
| tlr | input | 1 | Synchronous test-logic reset pulse |
| sysRst | input | 1 | System reset. The boot vector is captured while it is high |
| busWrEn | input | 1 | CPU register write enable |
| busRdEn | input | 1 | CPU register read enable |
| busModule | input | MOD_W | CPU register module number |
| busIndex | input | IDX_W | CPU register index |
| busWrData | input | DATA_W | CPU write data |
| busRdData | output | DATA_W | CPU read data (combinational) |
| jtagUpd | input | 1 | JTAG parallel update strobe |
| jtagSrcSel | input | SRC_W | JTAG source-select value to load |
| jtagEn | input | 1 | JTAG boot-enable value to load |
| jtagRod | input | 1 | Clears the JTAG boot-enable copy |
| xferDone | input | 1 | External transfer-complete flag |
| xferWrStrobe | output | 1 | CPU write to the register word |
| xferWrData | output | 1 | Write data for the transfer-complete flag |
| bootSel | output | 1 | Captured boot vector: 1 selects the loader |
| progIfSel | output | SRC_W | Effective programming-interface select |

## Verification
The bench builds the block with the default parameters: an 8-bit word, a two-bit select field, and the register at module 2, index 27. With an 8-bit word there are four reserved bits that must read 0. Using the defaults also lets the bench aim accesses at the neighbouring indices 26 and 28 and at module 3, to show that misses have no effect. The stimulus combines the three same-cycle collisions: CPU write with JTAG update, clear input with JTAG update, and test-logic reset with held state. It also runs two system-reset capture cycles that select opposite boot vectors.

// File: rtl/prog_ctl_pkg.sv
package prog_ctl_pkg;

  // Fixed bit positions in the register word (decoded by software)
  localparam int XFER_BIT = 0;
  localparam int EN_BIT   = 1;
  localparam int SRC_LSB  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic syncClr;      // test-logic reset: clear all copies
    logic cpuLoad;      // load CPU copies from bus data
    logic jtagSrcLoad;  // load JTAG select copy
    logic jtagSrcClr;   // clear JTAG select copy
    logic jtagEnLoad;   // load JTAG enable copy
    logic jtagEnClr;    // clear JTAG enable copy
    logic bootCapture;  // sample merged enable into boot vector
    logic rdHit;        // drive read word onto bus
  } ctl_strobe_t;

endpackage

// File: rtl/prog_ctl_ctrl.sv
module prog_ctl_ctrl
  import prog_ctl_pkg::*;
#(
  parameter int MOD_W      = 5,
  parameter int IDX_W      = 5,
  parameter int REG_MODULE = 2,
  parameter int REG_INDEX  = 27
) (
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [MOD_W-1:0] busModule,
  input  logic [IDX_W-1:0] busIndex,
  input  logic             jtagUpd,
  input  logic             jtagRod,
  input  logic             tlr,
  input  logic             sysRst,
  output ctl_strobe_t      strobes,
  output logic             xferWrStrobe
);

  localparam logic [MOD_W-1:0] MOD_MATCH = MOD_W'(REG_MODULE);
  localparam logic [IDX_W-1:0] IDX_MATCH = IDX_W'(REG_INDEX);

  logic addrHit;
  logic wrHit;

  assign addrHit = (busModule == MOD_MATCH) && (busIndex == IDX_MATCH);
  assign wrHit   = busWrEn && addrHit;

  always_comb begin
    strobes             = '0;
    strobes.syncClr     = tlr;
    strobes.cpuLoad     = wrHit && !tlr;
    // CPU write wins over a same-cycle JTAG update for the select copy
    strobes.jtagSrcClr  = wrHit;
    strobes.jtagSrcLoad = jtagUpd && !wrHit;
    // Clear input wins over a same-cycle update for the enable copy
    strobes.jtagEnClr   = jtagRod;
    strobes.jtagEnLoad  = jtagUpd && !jtagRod;
    strobes.bootCapture = sysRst;
    strobes.rdHit       = busRdEn && addrHit;
  end

  assign xferWrStrobe = wrHit;

endmodule

// File: rtl/prog_ctl_dp.sv
module prog_ctl_dp
  import prog_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  ctl_strobe_t       strobes,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [SRC_W-1:0]  jtagSrcSel,
  input  logic              jtagEn,
  input  logic              xferDone,
  output logic [DATA_W-1:0] busRdData,
  output logic              bootSel,
  output logic [SRC_W-1:0]  progIfSel,
  output logic [SRC_W-1:0]  cpuSrcQ,
  output logic              cpuEnQ,
  output logic [SRC_W-1:0]  jtagSrcQ,
  output logic              jtagEnQ,
  output logic              mergedEn
);

  localparam int RSVD_LSB = SRC_LSB + SRC_W;

  logic [SRC_W-1:0]  mergedSrc;
  logic [DATA_W-1:0] word;

  // CPU copies
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      cpuSrcQ <= '0;
      cpuEnQ  <= 1'b0;
    end else if (strobes.syncClr) begin
      cpuSrcQ <= '0;
      cpuEnQ  <= 1'b0;
    end else if (strobes.cpuLoad) begin
      cpuSrcQ <= busWrData[SRC_LSB +: SRC_W];
      cpuEnQ  <= busWrData[EN_BIT];
    end
  end

  // JTAG select copy
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      jtagSrcQ <= '0;
    end else if (strobes.syncClr || strobes.jtagSrcClr) begin
      jtagSrcQ <= '0;
    end else if (strobes.jtagSrcLoad) begin
      jtagSrcQ <= jtagSrcSel;
    end
  end

  // JTAG enable copy
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      jtagEnQ <= 1'b0;
    end else if (strobes.syncClr || strobes.jtagEnClr) begin
      jtagEnQ <= 1'b0;
    end else if (strobes.jtagEnLoad) begin
      jtagEnQ <= jtagEn;
    end
  end

  assign mergedSrc = cpuSrcQ | jtagSrcQ;
  assign mergedEn  = cpuEnQ | jtagEnQ;

  // Boot vector: tracks merged enable while system reset is held
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      bootSel <= 1'b0;
    end else if (strobes.bootCapture) begin
      bootSel <= mergedEn;
    end
  end

  assign progIfSel = mergedEn ? mergedSrc : '0;

  always_comb begin
    word                       = '0;
    word[XFER_BIT]             = xferDone;
    word[EN_BIT]               = mergedEn;
    word[SRC_LSB +: SRC_W]     = mergedSrc;
  end

  assign busRdData = strobes.rdHit ? word : '0;

  // Write bits that land on reserved or pass-through positions
  logic unusedWrBits;
  generate
    if (DATA_W > RSVD_LSB) begin : g_rsvd
      assign unusedWrBits = ^{busWrData[DATA_W-1:RSVD_LSB], busWrData[XFER_BIT]};
    end else begin : g_norsvd
      assign unusedWrBits = busWrData[XFER_BIT];
    end
  endgenerate

endmodule

// File: rtl/prog_ctl_reg.sv
module prog_ctl_reg
  import prog_ctl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SRC_W      = 2,
  parameter int MOD_W      = 5,
  parameter int IDX_W      = 5,
  parameter int REG_MODULE = 2,
  parameter int REG_INDEX  = 27
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              tlr,
  input  logic              sysRst,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [MOD_W-1:0]  busModule,
  input  logic [IDX_W-1:0]  busIndex,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              jtagUpd,
  input  logic [SRC_W-1:0]  jtagSrcSel,
  input  logic              jtagEn,
  input  logic              jtagRod,
  input  logic              xferDone,
  output logic              xferWrStrobe,
  output logic              xferWrData,
  output logic              bootSel,
  output logic [SRC_W-1:0]  progIfSel
);

  ctl_strobe_t      strobes;
  logic [SRC_W-1:0] cpuSrcQ;
  logic             cpuEnQ;
  logic [SRC_W-1:0] jtagSrcQ;
  logic             jtagEnQ;
  logic             mergedEn;

  prog_ctl_ctrl #(
    .MOD_W(MOD_W), .IDX_W(IDX_W),
    .REG_MODULE(REG_MODULE), .REG_INDEX(REG_INDEX)
  ) ctrl_i (
    .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busModule(busModule), .busIndex(busIndex),
    .jtagUpd(jtagUpd), .jtagRod(jtagRod),
    .tlr(tlr), .sysRst(sysRst),
    .strobes(strobes), .xferWrStrobe(xferWrStrobe)
  );

  prog_ctl_dp #(.DATA_W(DATA_W), .SRC_W(SRC_W)) dp_i (
    .clk(clk), .porRst_n(porRst_n), .strobes(strobes),
    .busWrData(busWrData), .jtagSrcSel(jtagSrcSel), .jtagEn(jtagEn),
    .xferDone(xferDone), .busRdData(busRdData),
    .bootSel(bootSel), .progIfSel(progIfSel),
    .cpuSrcQ(cpuSrcQ), .cpuEnQ(cpuEnQ),
    .jtagSrcQ(jtagSrcQ), .jtagEnQ(jtagEnQ), .mergedEn(mergedEn)
  );

  assign xferWrData = busWrData[XFER_BIT];

endmodule

// File: rtl/prog_ctl_chk.sv
module prog_ctl_chk
  import prog_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SRC_W  = 2
) (
  input logic              clk,
  input logic              porRst_n,
  input logic              tlr,
  input logic              sysRst,
  input logic              busWrEn,
  input logic              jtagRod,
  input logic              jtagUpd,
  input logic              xferWrStrobe,
  input logic              bootSel,
  input logic [SRC_W-1:0]  progIfSel,
  input logic [DATA_W-1:0] busRdData,
  input ctl_strobe_t       strobes,
  input logic [SRC_W-1:0]  cpuSrcQ,
  input logic              cpuEnQ,
  input logic [SRC_W-1:0]  jtagSrcQ,
  input logic              jtagEnQ,
  input logic              mergedEn
);

  localparam int RSVD_LSB = SRC_LSB + SRC_W;

  generate
    if (DATA_W > RSVD_LSB) begin : g_rsvd
      assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!porRst_n)
        busRdData[DATA_W-1:RSVD_LSB] == '0);
    end
  endgenerate

  assert_jtag_src_clr_R4: assert property (@(posedge clk) disable iff (!porRst_n)
    xferWrStrobe |=> (jtagSrcQ == '0));

  assert_collision_R5: assert property (@(posedge clk) disable iff (!porRst_n)
    (xferWrStrobe && jtagUpd) |=> (jtagSrcQ == '0));

  assert_rod_clr_R6: assert property (@(posedge clk) disable iff (!porRst_n)
    jtagRod |=> !jtagEnQ);

  assert_tlr_clr_R7: assert property (@(posedge clk) disable iff (!porRst_n)
    tlr |=> (cpuSrcQ == '0 && !cpuEnQ && jtagSrcQ == '0 && !jtagEnQ));

  assert_boot_hold_R8: assert property (@(posedge clk) disable iff (!porRst_n)
    !sysRst |=> $stable(bootSel));

  assert_boot_capture_R8: assert property (@(posedge clk) disable iff (!porRst_n)
    sysRst |=> (bootSel == $past(mergedEn)));

  assert_ifsel_off_R9: assert property (@(posedge clk) disable iff (!porRst_n)
    !mergedEn |-> (progIfSel == '0));

  assert_strobe_R10: assert property (@(posedge clk) disable iff (!porRst_n)
    xferWrStrobe |-> (busWrEn && strobes.jtagSrcClr));

endmodule

bind prog_ctl_reg prog_ctl_chk #(.DATA_W(DATA_W), .SRC_W(SRC_W)) chk_i (.*);

// File: tb/prog_ctl_reg_tb_top.sv
module prog_ctl_reg_tb_top;

  localparam int DATA_W = 8;
  localparam int SRC_W  = 2;
  localparam int MOD_W  = 5;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              porRst_n = 1'b0;
  logic              tlr = 1'b0;
  logic              sysRst = 1'b0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [MOD_W-1:0]  busModule = 5'd2;
  logic [IDX_W-1:0]  busIndex = 5'd27;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              jtagUpd = 1'b0;
  logic [SRC_W-1:0]  jtagSrcSel = '0;
  logic              jtagEn = 1'b0;
  logic              jtagRod = 1'b0;
  logic              xferDone = 1'b0;
  logic              xferWrStrobe;
  logic              xferWrData;
  logic              bootSel;
  logic [SRC_W-1:0]  progIfSel;

  int checks = 0;
  int failures = 0;

  logic [DATA_W-1:0] expQ[$];
  string             tagQ[$];

  always #10 clk = ~clk;  // 50 MHz

  prog_ctl_reg dut_i (
    .clk(clk), .porRst_n(porRst_n), .tlr(tlr), .sysRst(sysRst),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busModule(busModule),
    .busIndex(busIndex), .busWrData(busWrData), .busRdData(busRdData),
    .jtagUpd(jtagUpd), .jtagSrcSel(jtagSrcSel), .jtagEn(jtagEn),
    .jtagRod(jtagRod), .xferDone(xferDone), .xferWrStrobe(xferWrStrobe),
    .xferWrData(xferWrData), .bootSel(bootSel), .progIfSel(progIfSel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each read mid-cycle against the queue
  always @(negedge clk) begin
    #5;
    if (busRdEn) begin
      if (expQ.size() == 0) begin
        check("scoreboard-empty", 8'h1, 8'h0);
      end else begin
        check(tagQ.pop_front(), busRdData, expQ.pop_front());
      end
    end
  end

  task automatic cpuRead(input logic [4:0] m, input logic [4:0] i,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    busModule = m; busIndex = i; busRdEn = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b0; busModule = 5'd2; busIndex = 5'd27;
  endtask

  task automatic cpuWrite(input logic [4:0] m, input logic [4:0] i,
                          input logic [7:0] d, input logic expStrobe, input string tag);
    @(negedge clk);
    busModule = m; busIndex = i; busWrData = d; busWrEn = 1'b1;
    #5;
    check(tag, {7'd0, xferWrStrobe}, {7'd0, expStrobe});
    if (expStrobe) check(tag, {7'd0, xferWrData}, {7'd0, d[0]});
    @(negedge clk);
    busWrEn = 1'b0; busModule = 5'd2; busIndex = 5'd27;
  endtask

  task automatic jtagLoad(input logic [1:0] s, input logic e, input logic rod, input logic wr,
                          input logic [7:0] d);
    @(negedge clk);
    jtagUpd = 1'b1; jtagSrcSel = s; jtagEn = e; jtagRod = rod;
    busWrEn = wr; busWrData = d;
    @(negedge clk);
    jtagUpd = 1'b0; jtagRod = 1'b0; busWrEn = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) jtagRod = 1'b1;
    else if (which == 1) tlr = 1'b1;
    else sysRst = 1'b1;
    @(negedge clk);
    if (which == 2) @(negedge clk);
    jtagRod = 1'b0; tlr = 1'b0; sysRst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 8'h1, 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porRst_n = 1'b1;
    // Reset state
    cpuRead(2, 27, 8'h00, "R7 por state");
    #5; check("R8 bootSel after por", {7'd0, bootSel}, 8'h0);
    // R1 pass-through and layout
    xferDone = 1'b1;
    cpuRead(2, 27, 8'h01, "R1 xferDone bit0");
    xferDone = 1'b0;
    cpuWrite(2, 27, 8'hFF, 1'b1, "R10 strobe data1");
    cpuRead(2, 27, 8'h0E, "R1 reserved zero");
    #5; check("R9 ifsel enabled", {6'd0, progIfSel}, 8'h03);
    cpuWrite(2, 27, 8'h00, 1'b1, "R10 strobe data0");
    cpuRead(2, 27, 8'h00, "R4 cpu cleared");
    #5; check("R9 ifsel off", {6'd0, progIfSel}, 8'h00);
    // JTAG copies only
    jtagLoad(2'd2, 1'b1, 1'b0, 1'b0, 8'h00);
    cpuRead(2, 27, 8'h0A, "R2 R3 jtag copy visible");
    #5; check("R9 ifsel jtag", {6'd0, progIfSel}, 8'h02);
    // CPU write clears JTAG select, keeps JTAG enable
    cpuWrite(2, 27, 8'h04, 1'b1, "R10 strobe");
    cpuRead(2, 27, 8'h06, "R4 jtag src cleared en kept");
    #5; check("R9 ifsel cpu src", {6'd0, progIfSel}, 8'h01);
    // Clear input
    pulse(0);
    cpuRead(2, 27, 8'h04, "R6 rod clears jtag en");
    #5; check("R9 ifsel off en0", {6'd0, progIfSel}, 8'h00);
    // Clear input together with update
    jtagLoad(2'd2, 1'b1, 1'b1, 1'b0, 8'h00);
    cpuRead(2, 27, 8'h0C, "R6 rod beats update, R2 or");
    // CPU write together with update
    busModule = 5'd2; busIndex = 5'd27;
    jtagLoad(2'd3, 1'b1, 1'b0, 1'b1, 8'h00);
    cpuRead(2, 27, 8'h02, "R5 collision");
    // Misses
    cpuWrite(2, 26, 8'hFF, 1'b0, "R11 miss no strobe");
    cpuWrite(3, 27, 8'hFF, 1'b0, "R11 module miss no strobe");
    cpuRead(2, 27, 8'h02, "R11 miss write no change");
    cpuRead(2, 28, 8'h00, "R1 read miss index");
    cpuRead(3, 27, 8'h00, "R1 read miss module");
    // Boot capture
    pulse(2);
    #5; check("R8 capture loader", {7'd0, bootSel}, 8'h1);
    cpuRead(2, 27, 8'h02, "R7 sysRst keeps copies");
    pulse(0);
    cpuRead(2, 27, 8'h00, "R3 merged en now 0");
    #5; check("R8 hold after release", {7'd0, bootSel}, 8'h1);
    pulse(2);
    #5; check("R8 capture application", {7'd0, bootSel}, 8'h0);
    // Test-logic reset
    cpuWrite(2, 27, 8'h0E, 1'b1, "R10 strobe");
    jtagLoad(2'd1, 1'b1, 1'b0, 1'b0, 8'h00);
    cpuRead(2, 27, 8'h0E, "R2 R3 both set");
    pulse(1);
    cpuRead(2, 27, 8'h00, "R7 tlr clears");
    #5; check("R9 ifsel after tlr", {6'd0, progIfSel}, 8'h00);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule